// File: doc/BRIEF.md
# Secure-Mode Pre-Authentication Sequencer

This block is the control core of a security chip. It moves the chip from factory state to provisioned state and, once provisioned, runs a fixed authentication session with a remote key manager. Only after that session succeeds may the host processor enter secure mode. The sequencer does no cryptography itself. It issues numbered commands to external engines (key derivation, credential check, certificate verify, random draw, key agreement, MAC check, signing, hashing, sealed store) over a request/done port. It emits message tags and accepts inbound messages over a byte link with valid/ready handshakes. It keeps lifecycle and key-presence flags in a small register bank that stands in for non-volatile storage.

A run is started by a pulse on `auth_i`, which the system raises at power-on, or by an internal period timer. The first session after provisioning skips the device-credential check. Every session ends by sealing a hash of its session key, and the next session's first step checks the device against that hash. Any failed check or stalled engine aborts to idle with a sticky error code and leaves the permit low.

Top module: `preauth_seq`

## Requirements
- R1: After reset the lifecycle is manufactured (`lc_o`=0), `permit_o`, `step_o` and `err_o` are 0, and `eng_req_o`, `tx_valid_o` and `rx_ready_o` are low.
- R2: A pulse on `prov_i` in the manufactured state runs provisioning with `step_o`=7, in this order: send tag 0x51 (serial), engine op 1 (derive public key), receive manager key, send tag 0xA1 (own public key), receive certificate. The block then returns to idle with `lc_o`=1 (issued).
- R3: A `prov_i` pulse when not manufactured starts nothing, sets `err_o`=6 and leaves `lc_o` unchanged.
- R4: An `auth_i` pulse in the manufactured state starts no transfer, sets `err_o`=1 and keeps `permit_o` low.
- R5: The first session after provisioning runs steps 2 to 6 (`step_o`) with this traffic: send 0xA2, receive, op 3 (certificate verify), op 4 (random), op 5 (key agreement), then MSG_CNT times (receive, op 6 MAC check), op 7 (sign), send 0xA3, op 8 (hash), send 0xA4 (hash to device), op 9 (sealed store).
- R6: When op 9 completes, `permit_o` rises, `err_o` is 0 and `lc_o` becomes 2 (in use). `permit_o` is low from the first cycle of any new session.
- R7: Sessions in the in-use state begin at step 1 with op 2 (credential check). `eng_ok_i` low on it aborts with `err_o`=2.
- R8: `eng_ok_i` low on op 3 aborts the session with `err_o`=3.
- R9: `eng_ok_i` low on any op 6 aborts with `err_o`=4 before op 7 is issued.
- R10: An engine request not answered by `eng_done_i` within `tmo_cfg_i` cycles aborts with `err_o`=5. A zero `tmo_cfg_i` waits indefinitely.
- R11: With `per_cfg_i` nonzero and the lifecycle issued or in use, a new session starts after `per_cfg_i` idle cycles. A zero value never retriggers.
- R12: `tx_valid_o` and `tx_data_o` hold until `tx_ready_i`, and `eng_req_o` with `eng_op_o` holds until `eng_done_i`.
- R13: After an abort the block sits idle (`step_o`=0) with the error code held and the permit low until the next accepted start, which clears the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prov_i | input | 1 | Start provisioning (pulse) |
| auth_i | input | 1 | Start authentication session (pulse) |
| tmo_cfg_i | input | TMO_W | Engine timeout in cycles, 0 disables |
| per_cfg_i | input | PER_W | Re-authentication period in idle cycles, 0 disables |
| eng_req_o | output | 1 | Engine command request, held until done |
| eng_op_o | output | 4 | Engine command code |
| eng_done_i | input | 1 | Engine completion strobe |
| eng_ok_i | input | 1 | Engine verdict, sampled with done |
| tx_valid_o | output | 1 | Outbound message tag valid |
| tx_data_o | output | 8 | Outbound message tag |
| tx_ready_i | input | 1 | Link accepts tag |
| rx_valid_i | input | 1 | Inbound message available |
| rx_ready_o | output | 1 | Sequencer accepts inbound message |
| permit_o | output | 1 | Secure-mode entry permitted |
| step_o | output | 3 | Current step: 0 idle, 1..6 session, 7 provisioning |
| err_o | output | 3 | Sticky error code |
| lc_o | output | 2 | Lifecycle: 0 manufactured, 1 issued, 2 in use |

## Verification
A corrupted sequencer state shows up on the very next handshake. The order of engine codes and link transfers is logged and compared against the expected order of each session variant, so a skipped, repeated or reordered step is caught at the first out-of-place transfer. A wrong step or lifecycle register appears on `step_o` or `lc_o` within one cycle of the transition. A broken abort path shows as an error code that differs from the injected fault's code, or as a permit that rises when it should not. Timer faults show as an idle or stall window that is off by a cycle count the bench measures exactly.

// File: rtl/preauth_pkg.sv
package preauth_pkg;

  typedef enum logic [1:0] {LC_MANUF = 2'd0, LC_ISSUED = 2'd1, LC_INUSE = 2'd2} lc_e;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_NOT_ISSUED = 3'd1, E_CRED = 3'd2, E_CERT = 3'd3,
    E_TAMPER = 3'd4, E_TIMEOUT = 3'd5, E_BAD_STATE = 3'd6
  } err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_P_SN, S_P_DER, S_P_MGR, S_P_PUB, S_P_CERT,
    S_A_CRED, S_A_TXC, S_A_RXC, S_A_VER, S_A_RNG, S_A_KEY, S_A_MSG, S_A_MAC,
    S_A_SIGN, S_A_TXS, S_A_HASH, S_A_TXH, S_A_STORE
  } st_e;

  localparam logic [3:0] OP_DERIVE = 4'd1, OP_CRED = 4'd2, OP_VERIFY = 4'd3,
                         OP_RNG = 4'd4, OP_AGREE = 4'd5, OP_MAC = 4'd6,
                         OP_SIGN = 4'd7, OP_HASH = 4'd8, OP_SEAL = 4'd9;
  localparam logic [7:0] TAG_SN = 8'h51, TAG_PUB = 8'hA1, TAG_CERT = 8'hA2,
                         TAG_SIG = 8'hA3, TAG_HASH = 8'hA4;

  function automatic logic [3:0] eng_op(st_e s);
    case (s)
      S_P_DER:   return OP_DERIVE;
      S_A_CRED:  return OP_CRED;
      S_A_VER:   return OP_VERIFY;
      S_A_RNG:   return OP_RNG;
      S_A_KEY:   return OP_AGREE;
      S_A_MAC:   return OP_MAC;
      S_A_SIGN:  return OP_SIGN;
      S_A_HASH:  return OP_HASH;
      S_A_STORE: return OP_SEAL;
      default:   return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] tx_tag(st_e s);
    case (s)
      S_P_SN:  return TAG_SN;
      S_P_PUB: return TAG_PUB;
      S_A_TXC: return TAG_CERT;
      S_A_TXS: return TAG_SIG;
      S_A_TXH: return TAG_HASH;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic is_rx(st_e s);
    return (s == S_P_MGR) || (s == S_P_CERT) || (s == S_A_RXC) || (s == S_A_MSG);
  endfunction

  function automatic logic [2:0] step_of(st_e s);
    case (s)
      S_P_SN, S_P_DER, S_P_MGR, S_P_PUB, S_P_CERT: return 3'd7;
      S_A_CRED:                    return 3'd1;
      S_A_TXC, S_A_RXC, S_A_VER:   return 3'd2;
      S_A_RNG, S_A_KEY:            return 3'd3;
      S_A_MSG, S_A_MAC:            return 3'd4;
      S_A_SIGN, S_A_TXS:           return 3'd5;
      S_A_HASH, S_A_TXH, S_A_STORE: return 3'd6;
      default:                     return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/preauth_tmr.sv
module preauth_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  // zero limit disables; >= tolerates a limit lowered mid-count
  assign hit_o = en_i && (lim_i != '0) && (cnt_q >= lim_i - 1'b1);
endmodule

// File: rtl/preauth_nvreg.sv
module preauth_nvreg
  import preauth_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_pub_i,
  input  logic set_mgr_i,
  input  logic set_cert_i,
  input  logic set_issued_i,
  input  logic set_inuse_i,
  output lc_e  lc_o
);
  lc_e  lc_q;
  logic pub_q, mgr_q, cert_q, cred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q   <= LC_MANUF;
      pub_q  <= 1'b0;
      mgr_q  <= 1'b0;
      cert_q <= 1'b0;
      cred_q <= 1'b0;
    end else begin
      if (set_pub_i)  pub_q  <= 1'b1;
      if (set_mgr_i)  mgr_q  <= 1'b1;
      if (set_cert_i) cert_q <= 1'b1;
      if (set_issued_i) lc_q <= LC_ISSUED;
      if (set_inuse_i) begin
        lc_q   <= LC_INUSE;
        cred_q <= 1'b1;
      end
    end
  end

  assign lc_o = lc_q;

  assert_issued_keys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_q != LC_MANUF) |-> (pub_q && mgr_q && cert_q));
  assert_cred_inuse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_q |-> (lc_q == LC_INUSE));
endmodule

// File: rtl/preauth_seq.sv
module preauth_seq
  import preauth_pkg::*;
#(
  parameter int MSG_CNT = 2,
  parameter int TMO_W   = 8,
  parameter int PER_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prov_i,
  input  logic             auth_i,
  input  logic [TMO_W-1:0] tmo_cfg_i,
  input  logic [PER_W-1:0] per_cfg_i,
  output logic             eng_req_o,
  output logic [3:0]       eng_op_o,
  input  logic             eng_done_i,
  input  logic             eng_ok_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  input  logic             tx_ready_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  output logic             permit_o,
  output logic [2:0]       step_o,
  output logic [2:0]       err_o,
  output logic [1:0]       lc_o
);
  localparam int MW = $clog2(MSG_CNT + 1);

  st_e            state_q, state_d;
  err_e           err_q, err_d;
  logic           permit_q, permit_d;
  logic [MW-1:0]  msg_q, msg_d;
  lc_e            lc;
  logic           set_pub, set_mgr, set_cert, set_issued, set_inuse;
  logic           tmo_hit, per_hit, per_en;

  assign eng_req_o  = (eng_op(state_q) != 4'd0);
  assign eng_op_o   = eng_op(state_q);
  assign tx_data_o  = tx_tag(state_q);
  assign tx_valid_o = (tx_tag(state_q) != 8'd0);
  assign rx_ready_o = is_rx(state_q);
  assign per_en     = (state_q == S_IDLE) && (lc != LC_MANUF);

  preauth_tmr #(.W(TMO_W)) i_tmo (
    .clk_i, .rst_ni, .en_i(eng_req_o), .clr_i(state_d != state_q),
    .lim_i(tmo_cfg_i), .hit_o(tmo_hit));

  preauth_tmr #(.W(PER_W)) i_per (
    .clk_i, .rst_ni, .en_i(per_en), .clr_i(!per_en),
    .lim_i(per_cfg_i), .hit_o(per_hit));

  preauth_nvreg i_nv (
    .clk_i, .rst_ni, .set_pub_i(set_pub), .set_mgr_i(set_mgr),
    .set_cert_i(set_cert), .set_issued_i(set_issued), .set_inuse_i(set_inuse),
    .lc_o(lc));

  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    permit_d = permit_q;
    msg_d    = msg_q;
    {set_pub, set_mgr, set_cert, set_issued, set_inuse} = '0;
    unique case (state_q)
      S_IDLE:
        if (prov_i) begin
          if (lc == LC_MANUF) begin
            state_d = S_P_SN;
            err_d   = E_NONE;
          end else err_d = E_BAD_STATE;
        end else if (auth_i || per_hit) begin
          if (lc == LC_MANUF) err_d = E_NOT_ISSUED;
          else begin
            permit_d = 1'b0;
            err_d    = E_NONE;
            msg_d    = '0;
            // first session has no sealed credential yet
            state_d  = (lc == LC_ISSUED) ? S_A_TXC : S_A_CRED;
          end
        end
      S_P_SN:   if (tx_ready_i) state_d = S_P_DER;
      S_P_DER:  if (eng_done_i) begin state_d = S_P_MGR; set_pub = 1'b1; end
      S_P_MGR:  if (rx_valid_i) begin state_d = S_P_PUB; set_mgr = 1'b1; end
      S_P_PUB:  if (tx_ready_i) state_d = S_P_CERT;
      S_P_CERT: if (rx_valid_i) begin
                  state_d = S_IDLE; set_cert = 1'b1; set_issued = 1'b1;
                end
      S_A_CRED: if (eng_done_i) begin
                  if (eng_ok_i) state_d = S_A_TXC;
                  else begin state_d = S_IDLE; err_d = E_CRED; end
                end
      S_A_TXC:  if (tx_ready_i) state_d = S_A_RXC;
      S_A_RXC:  if (rx_valid_i) state_d = S_A_VER;
      S_A_VER:  if (eng_done_i) begin
                  if (eng_ok_i) state_d = S_A_RNG;
                  else begin state_d = S_IDLE; err_d = E_CERT; end
                end
      S_A_RNG:  if (eng_done_i) state_d = S_A_KEY;
      S_A_KEY:  if (eng_done_i) state_d = S_A_MSG;
      S_A_MSG:  if (rx_valid_i) state_d = S_A_MAC;
      S_A_MAC:  if (eng_done_i) begin
                  if (!eng_ok_i) begin state_d = S_IDLE; err_d = E_TAMPER; end
                  else if (msg_q == MW'(MSG_CNT - 1)) state_d = S_A_SIGN;
                  else begin state_d = S_A_MSG; msg_d = msg_q + 1'b1; end
                end
      S_A_SIGN: if (eng_done_i) state_d = S_A_TXS;
      S_A_TXS:  if (tx_ready_i) state_d = S_A_HASH;
      S_A_HASH: if (eng_done_i) state_d = S_A_TXH;
      S_A_TXH:  if (tx_ready_i) state_d = S_A_STORE;
      S_A_STORE: if (eng_done_i) begin
                  state_d = S_IDLE; permit_d = 1'b1; set_inuse = 1'b1;
                end
      default:  state_d = S_IDLE;
    endcase
    // done in the same cycle as the limit wins
    if (eng_req_o && !eng_done_i && tmo_hit) begin
      state_d = S_IDLE;
      err_d   = E_TIMEOUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      err_q    <= E_NONE;
      permit_q <= 1'b0;
      msg_q    <= '0;
    end else begin
      state_q  <= state_d;
      err_q    <= err_d;
      permit_q <= permit_d;
      msg_q    <= msg_d;
    end
  end

  assign permit_o = permit_q;
  assign step_o   = step_of(state_q);
  assign err_o    = err_q;
  assign lc_o     = lc;

  assert_permit_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(permit_q) |-> $past(state_q == S_A_STORE && eng_done_i));
  assert_permit_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && (state_d == S_A_CRED || state_d == S_A_TXC)) |=> !permit_o);
  assert_one_port_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_req_o, tx_valid_o, rx_ready_o}));
  assert_tx_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_eng_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && !eng_done_i && !tmo_hit) |=> (eng_req_o && $stable(eng_op_o)));
  assert_err_no_permit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != E_NONE) |-> !permit_o);
  assert_auth_issued_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o inside {[3'd1:3'd6]}) |-> (lc != LC_MANUF));
endmodule

// File: tb/test_preauth_seq.sv
module test_preauth_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prov = 1'b0, auth = 1'b0;
  logic [7:0] tmo = 8'd0;
  logic [15:0] per = 16'd0;
  logic       eng_req, eng_done = 1'b0, eng_ok = 1'b1;
  logic [3:0] eng_op;
  logic       tx_valid, tx_ready, rx_valid = 1'b1, rx_ready;
  logic [7:0] tx_data;
  logic       permit;
  logic [2:0] step, err;
  logic [1:0] lc;

  int nvec = 0, nerr = 0;
  int fail_op = 15, hang_op = 15;
  logic tx_stall = 1'b0;
  int trace[64];
  int ntr = 0;
  int exp_q[$];
  int steps_q[$];
  int c3 = 0;

  assign tx_ready = !tx_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  preauth_seq i_preauth_seq (
    .clk_i(clk), .rst_ni(rst_n), .prov_i(prov), .auth_i(auth),
    .tmo_cfg_i(tmo), .per_cfg_i(per),
    .eng_req_o(eng_req), .eng_op_o(eng_op), .eng_done_i(eng_done), .eng_ok_i(eng_ok),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .permit_o(permit), .step_o(step), .err_o(err), .lc_o(lc));

  function automatic void log_ev(int v);
    if (ntr < 64) trace[ntr] = v;
    ntr++;
  endfunction

  // engine stub and link logger; each handshake completes at the next posedge
  always @(negedge clk) begin
    if (eng_done) eng_done = 1'b0;
    else if (rst_n && eng_req && int'(eng_op) != hang_op) begin
      eng_done = 1'b1;
      eng_ok   = (int'(eng_op) != fail_op);
      log_ev(int'(eng_op));
    end
    if (rst_n && tx_valid && tx_ready) log_ev(32'h100 | int'(tx_data));
    if (rst_n && rx_ready && rx_valid) log_ev(32'h200);
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, int act, int expv);
    nvec++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic chk_trace(string req);
    chk({req, " transfer count"}, ntr, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ntr && i < 64; i++)
      if (trace[i] != exp_q[i]) begin
        chk({req, " transfer order"}, trace[i], exp_q[i]);
        break;
      end
  endtask

  task automatic clear_log();
    ntr = 0; exp_q.delete(); steps_q.delete(); c3 = 0;
  endtask

  task automatic start_auth();
    auth = 1'b1; tick(); auth = 1'b0;
  endtask

  task automatic wait_idle();
    int last = 0;
    for (int n = 0; n < 5000 && step != 3'd0; n++) begin
      if (int'(step) != last) begin steps_q.push_back(int'(step)); last = int'(step); end
      if (step == 3'd3) c3++;
      tick();
    end
  endtask

  task automatic push_tail();
    exp_q.push_back(32'h1A2); exp_q.push_back(32'h200); exp_q.push_back(3);
    exp_q.push_back(4); exp_q.push_back(5);
    for (int i = 0; i < 2; i++) begin exp_q.push_back(32'h200); exp_q.push_back(6); end
    exp_q.push_back(7); exp_q.push_back(32'h1A3); exp_q.push_back(8);
    exp_q.push_back(32'h1A4); exp_q.push_back(9);
  endtask

  task automatic t_reset();
    chk("R1 lc", int'(lc), 0);
    chk("R1 permit", int'(permit), 0);
    chk("R1 step", int'(step), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 ports idle", int'({eng_req, tx_valid, rx_ready}), 0);
  endtask

  task automatic t_unissued();
    clear_log(); start_auth(); tick();
    chk("R4 err", int'(err), 1);
    chk("R4 no transfer", ntr, 0);
    chk("R4 permit", int'(permit), 0);
  endtask

  task automatic t_provision();
    clear_log();
    prov = 1'b1; tick(); prov = 1'b0;
    chk("R2 step", int'(step), 7);
    wait_idle();
    exp_q = '{32'h151, 1, 32'h200, 32'h1A1, 32'h200};
    chk_trace("R2");
    chk("R2 lc issued", int'(lc), 1);
    chk("R2 err", int'(err), 0);
  endtask

  task automatic t_prov_again();
    clear_log();
    prov = 1'b1; tick(); prov = 1'b0; tick();
    chk("R3 err", int'(err), 6);
    chk("R3 lc", int'(lc), 1);
    chk("R3 no transfer", ntr, 0);
  endtask

  task automatic t_first();
    clear_log(); start_auth();
    chk("R5 first step skips credential", int'(step), 2);
    wait_idle();
    push_tail(); chk_trace("R5");
    chk("R5 step count", steps_q.size(), 5);
    if (steps_q.size() == 5)
      for (int i = 0; i < 5; i++) chk("R5 step order", steps_q[i], i + 2);
    chk("R6 permit", int'(permit), 1);
    chk("R6 lc in use", int'(lc), 2);
    chk("R6 err", int'(err), 0);
  endtask

  task automatic t_second();
    clear_log(); start_auth();
    chk("R6 permit cleared at start", int'(permit), 0);
    chk("R7 step 1", int'(step), 1);
    wait_idle();
    exp_q.push_back(2); push_tail(); chk_trace("R7");
    chk("R7 steps", steps_q.size(), 6);
    chk("R6 permit again", int'(permit), 1);
  endtask

  task automatic t_fault(string req, int op, int code);
    clear_log(); fail_op = op; start_auth(); wait_idle(); fail_op = 15;
    chk({req, " err"}, int'(err), code);
    chk({req, " permit"}, int'(permit), 0);
  endtask

  task automatic t_cred_fail();
    t_fault("R7", 2, 2);
    exp_q = '{2}; chk_trace("R7");
    repeat (10) tick();
    chk("R13 err sticky", int'(err), 2);
    chk("R13 idle", int'(step), 0);
    chk("R13 permit low", int'(permit), 0);
  endtask

  task automatic t_cert_fail();
    t_fault("R8", 3, 3);
    exp_q = '{2, 32'h1A2, 32'h200, 3}; chk_trace("R8");
  endtask

  task automatic t_mac_fail();
    t_fault("R9", 6, 4);
    exp_q = '{2, 32'h1A2, 32'h200, 3, 4, 5, 32'h200, 6}; chk_trace("R9");
  endtask

  task automatic t_recover();
    clear_log(); start_auth(); wait_idle();
    chk("R13 err cleared", int'(err), 0);
    chk("R13 permit restored", int'(permit), 1);
  endtask

  task automatic t_timeout();
    clear_log(); tmo = 8'd5; hang_op = 4;
    start_auth(); wait_idle(); hang_op = 15;
    chk("R10 err timeout", int'(err), 5);
    chk("R10 cycles waited", c3, 5);
    exp_q = '{2, 32'h1A2, 32'h200, 3}; chk_trace("R10");
  endtask

  task automatic t_no_timeout();
    clear_log(); tmo = 8'd0; hang_op = 4;
    start_auth();
    repeat (60) tick();
    chk("R10 still waiting", int'(step), 3);
    chk("R12 request held", int'(eng_req), 1);
    chk("R10 no error", int'(err), 0);
    hang_op = 15; wait_idle();
    chk("R10 completes", int'(permit), 1);
  endtask

  task automatic t_stall();
    logic [7:0] d;
    clear_log(); tx_stall = 1'b1; start_auth();
    for (int n = 0; n < 20 && !tx_valid; n++) tick();
    d = tx_data;
    chk("R12 tag", int'(d), 32'hA2);
    repeat (4) tick();
    chk("R12 valid held", int'(tx_valid), 1);
    chk("R12 data held", int'(tx_data), int'(d));
    tx_stall = 1'b0; wait_idle();
    chk("R12 session passes", int'(permit), 1);
  endtask

  task automatic t_periodic();
    int n = 0;
    clear_log(); per = 16'd20; start_auth(); wait_idle();
    while (step == 3'd0 && n < 100) begin n++; tick(); end
    chk("R11 idle cycles before retrigger", n, 20);
    chk("R11 permit cleared on retrigger", int'(permit), 0);
    per = 16'd0; wait_idle();
    chk("R11 periodic run passes", int'(permit), 1);
    n = 0;
    for (int i = 0; i < 100; i++) begin tick(); if (step != 3'd0) n++; end
    chk("R11 zero period no retrigger", n, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_unissued();
    t_provision();
    t_prov_again();
    t_first();
    t_second();
    t_cred_fail();
    t_cert_fail();
    t_mac_fail();
    t_recover();
    t_timeout();
    t_no_timeout();
    t_stall();
    t_periodic();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: run hung, actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule